// File: doc/BRIEF.md
# Prescaled Watchdog Countdown Timer

This block is a memory-mapped watchdog. A 16-bit down-counter is decremented once per tick of a power-of-two prescaler. Software configures it over a plain 32-bit register bus that carries an address, a write strobe, write data and read data. When the counter is enabled in watchdog mode and steps from one to zero, the block raises a reset request for one clock. A system reset controller elsewhere takes that request.

Software kicks the watchdog by writing the reload register. That write restarts the countdown at once and also restarts the prescaler phase. A reload value of zero parks the counter, so it never fires. Loading one with no prescaling makes the watchdog fire almost at once, which gives software a way to force a reset.

Top module: `wdog_tmr`

## Requirements
- R1: Writing byte offset 0x00 stores write-data bits [15:0] as the reload value and discards the higher bits. The same write copies that value into the counter. Reading 0x00 returns the reload value zero-extended.
- R2: The control word is at offset 0x08. Bits [3:0] are the prescale code, bits [5:4] are the mode and bit 7 is the enable. A read returns these fields with every other bit zero.
- R3: Offset 0x04 returns the current count and ignores writes. Any other offset reads as zero and ignores writes.
- R4: After reset the reload value, count, prescale code, mode and enable are all zero, and the reset request is low.
- R5: While enable is 1 and the count is nonzero, the count drops by one every 2^code clocks. The first step comes 2^code clocks after the most recent register write. That write restarts the prescaler phase and no step happens in the write cycle itself.
- R6: While enable is 0 the count holds its value.
- R7: In mode 3, the reset request rises on the clock edge where the count goes from 1 to 0. Loading 1 with code 0 while enabled raises the request at the second rising edge after the write is presented.
- R8: The reset request stays high for exactly one clock. The count then stays at zero until it is reloaded.
- R9: In any mode other than 3, the count still reaches zero but the reset request stays low.
- R10: A reload value of zero never raises the reset request.
- R11: Writing the reload register during a countdown restarts the timeout from the new value. This is the kick.
- R12: A control write that turns enable from 0 to 1 copies the stored reload value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-clock reset request on watchdog expiry |

## Verification
The hardest case to reach from the ports is expiry at the largest prescale code. A single count then spans 32768 clocks, and both the clock before expiry and the expiry clock must be observed. The stimulus loads one with code 15 and waits out the full window. It then checks that the request is still low on the last clock before expiry and high on the expiry clock. Kicks issued in the middle of a prescaled window are compared clock by clock against a behavioural model. That comparison shows the prescaler phase restarting and not carrying over from before the kick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int DATA_W = 32;
   localparam int PSC_W  = 4;
   localparam int MODE_W = 2;
   localparam int EN_BIT = 7;
   localparam int MODE_LSB = 4;

   localparam logic [7:0] OFS_RELOAD = 8'h00;
   localparam logic [7:0] OFS_COUNT  = 8'h04;
   localparam logic [7:0] OFS_CTRL   = 8'h08;

   localparam logic [MODE_W-1:0] MODE_WDOG = 2'd3;

   typedef enum logic [1:0] {
      SEL_RELOAD,
      SEL_COUNT,
      SEL_CTRL,
      SEL_NONE
   } reg_sel_e;

   typedef struct packed {
      logic              en;
      logic [MODE_W-1:0] mode;
      logic [PSC_W-1:0]  psc;
   } ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [CNT_W-1:0]    cnt,
   output logic [CNT_W-1:0]    reload_q,
   output ctl_t                ctl_q,
   output logic                reload_wr,
   output logic                ctl_wr,
   output logic                rearm,
   output logic [DATA_W-1:0]   rdata
);
   reg_sel_e sel;

   always_comb begin
      if (addr == ADDR_W'(OFS_RELOAD))      sel = SEL_RELOAD;
      else if (addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
      else if (addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
      else                                  sel = SEL_NONE;
   end

   assign reload_wr = we && (sel == SEL_RELOAD);
   assign ctl_wr    = we && (sel == SEL_CTRL);
   assign rearm     = ctl_wr && wdata[EN_BIT] && !ctl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctl_q    <= '0;
      end else begin
         if (reload_wr) reload_q <= wdata[CNT_W-1:0];
         if (ctl_wr) begin
            ctl_q.en   <= wdata[EN_BIT];
            ctl_q.mode <= wdata[MODE_LSB +: MODE_W];
            ctl_q.psc  <= wdata[PSC_W-1:0];
         end
      end
   end

   logic [DATA_W-1:0] ctl_rd;
   always_comb begin
      ctl_rd                        = '0;
      ctl_rd[EN_BIT]                = ctl_q.en;
      ctl_rd[MODE_LSB +: MODE_W]    = ctl_q.mode;
      ctl_rd[PSC_W-1:0]             = ctl_q.psc;
   end

   always_comb begin
      unique case (sel)
         SEL_RELOAD: rdata = DATA_W'(reload_q);
         SEL_COUNT:  rdata = DATA_W'(cnt);
         SEL_CTRL:   rdata = ctl_rd;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
   import wdog_pkg::*;
#(
   parameter int CODE_W = PSC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int DIV_W = (2 ** CODE_W) - 1;

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] mask;

   for (genvar i = 0; i < DIV_W; i++) begin : g_mask
      assign mask[i] = (int'(code) > i);
   end

   assign tick = run && !clr && ((phase_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (clr)    phase_q <= '0;
      else if (run)    phase_q <= phase_q + DIV_W'(1);
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             rearm,
   input  logic [CNT_W-1:0] reload_q,
   input  logic             tick,
   input  logic             wdog_mode,
   output logic [CNT_W-1:0] cnt_q,
   output logic             req_q
);
   logic live;
   logic last;

   assign live = tick && !reload_wr && !rearm && (cnt_q != '0);
   assign last = live && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= last && wdog_mode;
         if (reload_wr)  cnt_q <= wr_val;
         else if (rearm) cnt_q <= reload_q;
         else if (live)  cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wdog_tmr.sv
module wdog_tmr
   import wdog_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdog_tmr: CNT_W must be between 1 and the bus width");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("wdog_tmr: ADDR_W must cover offset 0x08");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   ctl_t             ctl_q;
   logic             reload_wr;
   logic             ctl_wr;
   logic             rearm;
   logic             tick;
   logic             ctl_en;
   logic [MODE_W-1:0] ctl_mode;

   assign ctl_en   = ctl_q.en;
   assign ctl_mode = ctl_q.mode;

   wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .we        (bus_we),
      .wdata     (bus_wdata),
      .cnt       (cnt_q),
      .reload_q  (reload_q),
      .ctl_q     (ctl_q),
      .reload_wr (reload_wr),
      .ctl_wr    (ctl_wr),
      .rearm     (rearm),
      .rdata     (bus_rdata)
   );

   wdog_prescale #(.CODE_W(PSC_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl_en),
      .clr   (reload_wr || ctl_wr),
      .code  (ctl_q.psc),
      .tick  (tick)
   );

   wdog_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload_wr (reload_wr),
      .wr_val    (bus_wdata[CNT_W-1:0]),
      .rearm     (rearm),
      .reload_q  (reload_q),
      .tick      (tick),
      .wdog_mode (ctl_mode == MODE_WDOG),
      .cnt_q     (cnt_q),
      .req_q     (rst_req)
   );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic [1:0]       mode,
   input logic             rst_req
);
   // R8: request is a single-clock pulse
   assert_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R7: request coincides with the count having reached zero
   assert_req_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == '0));

   // R5: without a write the count only holds or steps down by one
   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1)));

   // R6: disabled counter holds
   assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bus_we) |=> $stable(cnt));

   // R10: a zero count cannot produce a request
   assert_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |=> !rst_req);

   // R9: no request outside watchdog mode
   assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd3) |=> !rst_req);
endmodule

bind wdog_tmr wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_we  (bus_we),
   .cnt     (cnt_q),
   .en      (ctl_en),
   .mode    (ctl_mode),
   .rst_req (rst_req)
);

// File: tb/wdog_tmr_test.sv
module wdog_tmr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wdog_tmr uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rst_req   (rst_req)
   );

   // behavioural reference
   int m_reload, m_cnt, m_psc, m_mode, m_en, m_phase, m_req;

   function automatic int model_read(int a);
      if (a == 0) return m_reload;
      if (a == 4) return m_cnt;
      if (a == 8) return (m_en << 7) | (m_mode << 4) | m_psc;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reload = 0; m_cnt = 0; m_psc = 0; m_mode = 0;
         m_en = 0; m_phase = 0; m_req = 0;
      end else begin
         int a, d, span;
         bit wr_any, wr_rel, wr_ctl, stepping;
         a = int'(bus_addr); d = int'(bus_wdata);
         wr_rel = bus_we && a == 0;
         wr_ctl = bus_we && a == 8;
         wr_any = wr_rel || wr_ctl;
         span = 1 << m_psc;
         stepping = m_en != 0 && !wr_any && (m_phase % span) == span - 1 && m_cnt != 0;
         m_req = (stepping && m_cnt == 1 && m_mode == 3) ? 1 : 0;
         if (wr_rel) m_cnt = d & 16'hFFFF;
         else if (wr_ctl && ((d >> 7) & 1) == 1 && m_en == 0) m_cnt = m_reload;
         else if (stepping) m_cnt = m_cnt - 1;
         if (wr_any) m_phase = 0;
         else if (m_en != 0) m_phase = (m_phase + 1) % 32768;
         if (wr_rel) m_reload = d & 16'hFFFF;
         if (wr_ctl) begin
            m_en = (d >> 7) & 1; m_mode = (d >> 4) & 3; m_psc = d & 15;
         end
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // clock-by-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rst_req == m_req[0], "R7/R8 model rst_req", int'(rst_req), m_req);
         check(int'(bus_rdata) == model_read(int'(bus_addr)), "R1/R2/R3 model rdata",
               int'(bus_rdata), model_read(int'(bus_addr)));
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic rd(logic [3:0] a, output int v);
      bus_addr = a;
      @(negedge clk);
      v = int'(bus_rdata);
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int v;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R4 reset state
      check(rst_req == 1'b0, "R4 rst_req", int'(rst_req), 0);
      rd(4'h0, v); check(v == 0, "R4 reload", v, 0);
      rd(4'h4, v); check(v == 0, "R4 count", v, 0);
      rd(4'h8, v); check(v == 0, "R4 ctrl", v, 0);

      // R1 reload write truncates and loads the counter
      wr(4'h0, 32'h0001_ABCD);
      rd(4'h0, v); check(v == 32'hABCD, "R1 reload readback", v, 32'hABCD);
      rd(4'h4, v); check(v == 32'hABCD, "R1 count loaded", v, 32'hABCD);

      // R2 control fields; bit 6 and upper bits read zero
      wr(4'h8, 32'hFFFF_FF7F & ~32'h80);
      rd(4'h8, v); check(v == 32'h3F, "R2 ctrl readback", v, 32'h3F);

      // R3 count is read-only, unmapped reads zero
      wr(4'h4, 32'h0000_0055);
      rd(4'h4, v); check(v == 32'hABCD, "R3 count ignores write", v, 32'hABCD);
      wr(4'hC, 32'h1234_5678);
      rd(4'hC, v); check(v == 0, "R3 unmapped reads zero", v, 0);

      // R6 disabled hold, then R5 code 0 counting
      wr(4'h0, 32'd100);
      idle(5);
      rd(4'h4, v); check(v == 100, "R6 hold while disabled", v, 100);
      wr(4'h8, 32'h80);            // enable, mode 0, code 0
      idle(9);
      rd(4'h4, v); check(v == 90, "R5 code0 ten steps", v, 90);
      wr(4'h8, 32'h00);            // disable
      rd(4'h4, v);
      idle(6);
      begin
         int w;
         rd(4'h4, w); check(w == v, "R6 hold after disable", w, v);
      end

      // R12 re-enable copies reload value
      wr(4'h8, 32'h80);
      rd(4'h4, v); check(v == 99, "R12 rearm reload then one step", v, 99);

      // R9 mode 0 reaches zero silently
      wr(4'h0, 32'd2);
      idle(6);
      rd(4'h4, v); check(v == 0, "R9 count zero in mode 0", v, 0);
      check(rst_req == 1'b0, "R9 no request", int'(rst_req), 0);

      // R10 zero reload never fires
      wr(4'h8, 32'hB0);
      wr(4'h0, 32'd0);
      idle(20);
      check(rst_req == 1'b0, "R10 zero reload quiet", int'(rst_req), 0);

      // R7 load one with code 0: request at second edge after write
      wr(4'h0, 32'd1);
      bus_addr = 4'h4;
      @(negedge clk);
      check(rst_req == 1'b1, "R7 immediate expiry", int'(rst_req), 1);
      @(negedge clk);
      check(rst_req == 1'b0, "R8 pulse one clock", int'(rst_req), 0);
      check(bus_rdata == 32'h0, "R8 count stays zero", int'(bus_rdata), 0);
      #1;
      idle(10);
      rd(4'h4, v); check(v == 0, "R8 still zero", v, 0);

      // R5 code 2 with load 3: expiry twelve edges after the write
      wr(4'h8, 32'hB2);
      wr(4'h0, 32'd3);
      idle(10);
      @(negedge clk);
      check(rst_req == 1'b0, "R5 code2 not yet", int'(rst_req), 0);
      @(negedge clk);
      check(rst_req == 1'b1, "R5 code2 expiry", int'(rst_req), 1);
      #1;

      // R11 kick mid-window with code 1
      wr(4'h8, 32'hB1);
      wr(4'h0, 32'd4);
      idle(5);
      wr(4'h0, 32'd4);
      idle(6);
      check(rst_req == 1'b0, "R11 kick delays expiry", int'(rst_req), 0);
      rd(4'h4, v); check(v == 1, "R11 count after kick", v, 1);
      idle(3);

      // R5 largest code: one count lasts 32768 clocks
      wr(4'h8, 32'hBF);
      wr(4'h0, 32'd1);
      idle(32766);
      @(negedge clk);
      check(rst_req == 1'b0, "R5 code15 not yet", int'(rst_req), 0);
      @(negedge clk);
      check(rst_req == 1'b1, "R5 code15 expiry", int'(rst_req), 1);
      #1;
      idle(3);
      finish_run();
   end
endmodule